// File: doc/BRIEF.md
# Two-Source Select Permute

This block builds one output vector from two source buffers, X and Y. Each source goes through its own permute, set by a start value, a packed set of 4-bit per-lane offsets and, for 16-bit elements, a square field that reorders halfwords inside small blocks. A per-lane mask then chooses, for every output lane, whether the lane comes from the permuted X candidate or the permuted Y candidate. Interleaving, de-interleaving, broadcasting and merging two vectors can all be expressed this way without moving the data first.

Each source buffer holds BUF_WORDS 32-bit words, 1024 bits by default. The output is OUT_WORDS words, 512 bits by default. In 32-bit mode the output has 16 lanes of 32 bits. In 16-bit mode it has 32 lanes of 16 bits. A half-lanes control keeps only the lower half of the lanes and forces the upper half to zero. Both candidates are computed side by side in combinational logic. The chosen result is captured once, on a cycle where `in_valid` is high, and is presented one cycle later with `out_valid`.

Top module: `sel_permute`

## Requirements
- R1: While `rst_n` is low, and right after it rises, `out_data` is all zeros and `out_valid` is 0.
- R2: `out_valid` equals the value of `in_valid` one clock edge earlier. `out_data` loads a new result only on an edge where `in_valid` is 1 and keeps its value otherwise.
- R3: In 32-bit mode (`mode16`=0), output lane i (i = 0..15, bits 32i+31:32i) of the X candidate is source word (x_start + x_ofs[4i+3:4i]) mod 32. Word w of a buffer occupies bits 32w+31:32w. Bit 5 of the start value is ignored. The Y candidate is formed the same way from the Y controls.
- R4: Mask bit i governs output lane i, with bit 0 for lane 0. A 0 takes the lane from the X candidate and a 1 takes it from the Y candidate. In 32-bit mode mask bits 31:16 have no effect.
- R5: In 16-bit mode, lane group k (lanes 4k..4k+3) uses the offset pair a = ofs[8k+3:8k] and b = ofs[8k+7:8k+4]. With base = start[5:1], word w0 = (base+a) mod 32 and word w1 = (base+a+b+1) mod 32. Together they form the block {w0 low half, w0 high half, w1 low half, w1 high half}, numbered 0..3. Halfword e of a buffer occupies bits 16e+15:16e, with the low half of word w being halfword 2w.
- R6: In 16-bit mode, lane 4k+j (j = 0..3) takes block element (sq[4j+3:4j] mod 4). X and Y each use their own square field.
- R7: When `half_lanes` is 1, bits 511:256 of the result are zero in both modes. The lower lanes are unaffected.
- R8: With one buffer fed to both sides, these two settings must interleave. (a) 32-bit mode, mask 0xAAAA, X start 0 with offsets 0x0706050403020100, Y start 8 with offsets 0x7060504030201000: the even lanes take words 0..7 and the odd lanes take words 8..15. (b) 16-bit mode, mask 0xAAAAAAAA, X start 0, Y start 32, offsets 0x0706050403020100 and square 0x1100 on both sides, with halfwords holding 0..63: the result is 0,32,1,33,...,15,47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the current inputs |
| mode16 | input | 1 | 0: 16 lanes of 32 bits; 1: 32 lanes of 16 bits |
| half_lanes | input | 1 | Zero the upper half of the output lanes |
| sel_mask | input | 32 | Per-lane source choice (1 = Y) |
| x_buf | input | 1024 | X source buffer |
| x_start | input | 6 | X start, in element units |
| x_ofs | input | 64 | X packed 4-bit offsets |
| x_sq | input | 16 | X square field (16-bit mode) |
| y_buf | input | 1024 | Y source buffer |
| y_start | input | 6 | Y start, in element units |
| y_ofs | input | 64 | Y packed 4-bit offsets |
| y_sq | input | 16 | Y square field (16-bit mode) |
| out_valid | output | 1 | Result valid, one cycle after capture |
| out_data | output | 512 | Registered result vector |

## Verification
The two interleave settings are applied first. They fix the mask polarity, the offset-pair arithmetic and the square digit order, and in those settings a swapped nibble or digit moves a known value to a visibly wrong lane. Next, a sweep runs every start value 0..63 in both modes against buffers filled with distinct hashed words, using pseudo-random offsets, squares and masks. Distinct words separate X from Y, a word from its neighbour, and a low halfword from a high one. Starts near 31 combined with large offsets force the index to wrap. Uniform-offset cases check the modulo wrap on their own. Further cases cover the half-lane mode, the mask bits that 32-bit mode ignores, a square field that rotates the block, and holding the inputs idle while they change.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic {
    LANE32 = 1'b0,
    LANE16 = 1'b1
  } lane_mode_e;

  localparam int WORD_W    = 32;
  localparam int ELEM_W    = 16;
  localparam int OFS_W     = 4;
  localparam int SQ_DIGITS = 4;
endpackage

// File: rtl/sp_perm_src.sv
// One source permute: produces the candidate vector for either lane mode.
module sp_perm_src
  import sp_pkg::*;
#(
  parameter  int BUF_WORDS = 32,
  parameter  int OUT_WORDS = 16,
  localparam int IDX_W     = $clog2(BUF_WORDS),
  localparam int START_W   = IDX_W + 1,
  localparam int GROUPS    = OUT_WORDS / 2,
  localparam int BUF_W     = WORD_W * BUF_WORDS,
  localparam int OUT_W     = WORD_W * OUT_WORDS
) (
  input  logic [BUF_W-1:0]             src,
  input  logic [START_W-1:0]           start,
  input  logic [OUT_WORDS*OFS_W-1:0]   ofs,
  input  logic [SQ_DIGITS*OFS_W-1:0]   sq,
  input  lane_mode_e                   mode,
  output logic [OUT_W-1:0]             cand
);

  // Word index arithmetic; the buffer depth is a power of two so the
  // truncation to IDX_W bits is the modulo.
  function automatic logic [IDX_W-1:0] wrap_idx(input logic [IDX_W-1:0] base,
                                                input logic [OFS_W-1:0] a,
                                                input logic [4:0]       extra);
    return IDX_W'(base + IDX_W'(a) + IDX_W'(extra));
  endfunction

  logic [OUT_W-1:0] cand32;
  logic [OUT_W-1:0] cand16;
  logic [IDX_W-1:0] base32;
  logic [IDX_W-1:0] base16;

  assign base32 = start[IDX_W-1:0];
  assign base16 = start[START_W-1:1];

  // 32-bit lanes: one offset nibble per lane.
  for (genvar i = 0; i < OUT_WORDS; i++) begin : g_w32
    logic [IDX_W-1:0] widx;
    assign widx = wrap_idx(base32, ofs[OFS_W*i +: OFS_W], 5'd0);
    assign cand32[WORD_W*i +: WORD_W] = src[widx*WORD_W +: WORD_W];
  end

  // 16-bit lanes: a nibble pair per group of four lanes, then square.
  for (genvar k = 0; k < GROUPS; k++) begin : g_h16
    logic [OFS_W-1:0]    a_nib;
    logic [OFS_W-1:0]    b_nib;
    logic [IDX_W-1:0]    w0;
    logic [IDX_W-1:0]    w1;
    logic [2*WORD_W-1:0] blk;
    logic [8*WORD_W-1:0] blk_rep;
    assign a_nib   = ofs[2*OFS_W*k +: OFS_W];
    assign b_nib   = ofs[2*OFS_W*k + OFS_W +: OFS_W];
    assign w0      = wrap_idx(base16, a_nib, 5'd0);
    assign w1      = wrap_idx(base16, a_nib, {1'b0, b_nib} + 5'd1);
    assign blk     = {src[w1*WORD_W +: WORD_W], src[w0*WORD_W +: WORD_W]};
    // Replicated so a full square digit indexes it modulo four.
    assign blk_rep = {4{blk}};
    for (genvar j = 0; j < SQ_DIGITS; j++) begin : g_sq
      assign cand16[ELEM_W*(SQ_DIGITS*k + j) +: ELEM_W] =
        blk_rep[sq[OFS_W*j +: OFS_W]*ELEM_W +: ELEM_W];
    end
  end

  assign cand = (mode == LANE16) ? cand16 : cand32;

endmodule

// File: rtl/sp_lane_pick.sv
// Per-lane source choice and lane enable, resolved at halfword granularity.
module sp_lane_pick
  import sp_pkg::*;
#(
  parameter  int OUT_WORDS = 16,
  localparam int HL        = 2 * OUT_WORDS,
  localparam int OUT_W     = WORD_W * OUT_WORDS
) (
  input  logic [OUT_W-1:0] x_cand,
  input  logic [OUT_W-1:0] y_cand,
  input  logic [HL-1:0]    mask,
  input  lane_mode_e       mode,
  input  logic             half,
  output logic [HL-1:0]    pick_y,
  output logic [OUT_W-1:0] res
);

  for (genvar l = 0; l < HL; l++) begin : g_hw
    logic lane_en;
    assign pick_y[l] = (mode == LANE16) ? mask[l] : mask[l/2];
    assign lane_en   = !half || (l < HL/2);
    assign res[ELEM_W*l +: ELEM_W] =
      !lane_en  ? '0 :
      pick_y[l] ? y_cand[ELEM_W*l +: ELEM_W] : x_cand[ELEM_W*l +: ELEM_W];
  end

endmodule

// File: rtl/sel_permute.sv
module sel_permute
  import sp_pkg::*;
#(
  parameter  int BUF_WORDS = 32,
  parameter  int OUT_WORDS = 16,
  localparam int IDX_W     = $clog2(BUF_WORDS),
  localparam int START_W   = IDX_W + 1,
  localparam int HL        = 2 * OUT_WORDS,
  localparam int OUT_W     = WORD_W * OUT_WORDS,
  localparam int BUF_W     = WORD_W * BUF_WORDS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       mode16,
  input  logic                       half_lanes,
  input  logic [HL-1:0]              sel_mask,
  input  logic [BUF_W-1:0]           x_buf,
  input  logic [START_W-1:0]         x_start,
  input  logic [OUT_WORDS*OFS_W-1:0] x_ofs,
  input  logic [SQ_DIGITS*OFS_W-1:0] x_sq,
  input  logic [BUF_W-1:0]           y_buf,
  input  logic [START_W-1:0]         y_start,
  input  logic [OUT_WORDS*OFS_W-1:0] y_ofs,
  input  logic [SQ_DIGITS*OFS_W-1:0] y_sq,
  output logic                       out_valid,
  output logic [OUT_W-1:0]           out_data
);

  lane_mode_e       mode;
  logic [OUT_W-1:0] x_cand;
  logic [OUT_W-1:0] y_cand;
  logic [OUT_W-1:0] picked;
  logic [HL-1:0]    pick_y_hw;

  assign mode = lane_mode_e'(mode16);

  sp_perm_src #(.BUF_WORDS(BUF_WORDS), .OUT_WORDS(OUT_WORDS)) u_xsrc (
    .src(x_buf), .start(x_start), .ofs(x_ofs), .sq(x_sq), .mode(mode), .cand(x_cand)
  );

  sp_perm_src #(.BUF_WORDS(BUF_WORDS), .OUT_WORDS(OUT_WORDS)) u_ysrc (
    .src(y_buf), .start(y_start), .ofs(y_ofs), .sq(y_sq), .mode(mode), .cand(y_cand)
  );

  sp_lane_pick #(.OUT_WORDS(OUT_WORDS)) u_pick (
    .x_cand(x_cand), .y_cand(y_cand), .mask(sel_mask), .mode(mode),
    .half(half_lanes), .pick_y(pick_y_hw), .res(picked)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= picked;
    end
  end

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data)));

  // R4
  all_x_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !half_lanes && sel_mask == '0) |=> out_data == $past(x_cand));

  // R4
  all_y_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !half_lanes && sel_mask == '1) |=> out_data == $past(y_cand));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && half_lanes) |=> out_data[OUT_W-1:OUT_W/2] == '0);

  // R4
  mask_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == LANE32) |-> $countones(pick_y_hw) == 2 * $countones(sel_mask[HL/2-1:0]));

endmodule

// File: tb/sel_permute_test.sv
`timescale 1ns/1ps
module sel_permute_test;
  localparam real HALF = 2.5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          mode16 = 1'b0;
  logic          half_lanes = 1'b0;
  logic [31:0]   sel_mask = '0;
  logic [1023:0] x_buf = '0, y_buf = '0;
  logic [5:0]    x_start = '0, y_start = '0;
  logic [63:0]   x_ofs = '0, y_ofs = '0;
  logic [15:0]   x_sq = '0, y_sq = '0;
  logic          out_valid;
  logic [511:0]  out_data;

  int total = 0;
  int fails = 0;
  bit done = 0;
  logic [63:0] rs = 64'h0123_4567_89AB_CDEF;

  always #(HALF) clk = ~clk;

  sel_permute uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode16(mode16),
    .half_lanes(half_lanes), .sel_mask(sel_mask),
    .x_buf(x_buf), .x_start(x_start), .x_ofs(x_ofs), .x_sq(x_sq),
    .y_buf(y_buf), .y_start(y_start), .y_ofs(y_ofs), .y_sq(y_sq),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nxt(output logic [63:0] v);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    v = rs;
  endtask

  function automatic logic [1023:0] fill(input int seed);
    logic [1023:0] b;
    for (int k = 0; k < 32; k++)
      b[32*k +: 32] = (32'(k) + 32'd1) * 32'h9E37_79B1 ^ (32'(seed) * 32'h85EB_CA6B);
    return b;
  endfunction

  // Element fetch restated from R3/R5/R6 at element level.
  function automatic logic [31:0] elem(input logic [1023:0] b, input int st,
                                      input logic [63:0] o, input logic [15:0] q,
                                      input bit m16, input int lane);
    if (!m16) begin
      int w;
      w = (st + int'(o[4*lane +: 4])) % 32;
      return b[32*w +: 32];
    end else begin
      int k, j, s, a, bb, w, e;
      k = lane / 4; j = lane % 4;
      s = int'(q[4*j +: 4]) % 4;
      a = int'(o[8*k +: 4]); bb = int'(o[8*k+4 +: 4]);
      w = (st / 2 + a + ((s >= 2) ? bb + 1 : 0)) % 32;
      e = 2 * w + s % 2;
      return {16'h0, b[16*e +: 16]};
    end
  endfunction

  function automatic logic [511:0] model();
    logic [511:0] r;
    int n;
    r = '0;
    n = mode16 ? 32 : 16;
    for (int l = 0; l < n; l++) begin
      logic [31:0] v;
      v = sel_mask[l] ? elem(y_buf, int'(y_start), y_ofs, y_sq, mode16, l)
                      : elem(x_buf, int'(x_start), x_ofs, x_sq, mode16, l);
      if (half_lanes && l >= n / 2) v = '0;
      if (mode16) r[16*l +: 16] = v[15:0];
      else        r[32*l +: 32] = v;
    end
    return r;
  endfunction

  // Inputs are set at a falling edge; capture at the next rising edge,
  // result sampled at the falling edge after it.
  task automatic fire(input string req);
    logic [511:0] exp;
    exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(req, out_data, exp);
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [511:0] exp, held;
    logic [63:0] v;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 data", out_data, '0);
    chk("R1 valid", {511'd0, out_valid}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {out_data[510:0], out_valid}, '0);

    // R8 (a): 32-bit interleave
    x_buf = fill(7);
    for (int k = 0; k < 16; k++) x_buf[32*k +: 32] = 32'd1000 + 32'(k);
    y_buf = x_buf;
    mode16 = 0; half_lanes = 0; sel_mask = 32'h0000_AAAA;
    x_start = 0; x_ofs = 64'h0706050403020100;
    y_start = 8; y_ofs = 64'h7060504030201000;
    for (int k = 0; k < 8; k++) begin
      exp[64*k +: 32]      = 32'd1000 + 32'(k);
      exp[64*k + 32 +: 32] = 32'd1008 + 32'(k);
    end
    in_valid = 1; @(negedge clk); in_valid = 0;
    chk("R8 interleave32", out_data, exp);
    chk("R2 valid after capture", {511'd0, out_valid}, 512'd1);

    // R8 (b): 16-bit interleave
    for (int e = 0; e < 64; e++) x_buf[16*e +: 16] = 16'(e);
    y_buf = x_buf;
    mode16 = 1; sel_mask = 32'hAAAA_AAAA;
    x_start = 0; y_start = 32;
    x_ofs = 64'h0706050403020100; y_ofs = x_ofs;
    x_sq = 16'h1100; y_sq = 16'h1100;
    for (int k = 0; k < 16; k++) begin
      exp[32*k +: 16]      = 16'(k);
      exp[32*k + 16 +: 16] = 16'(32 + k);
    end
    in_valid = 1; @(negedge clk); in_valid = 0;
    chk("R8 interleave16", out_data, exp);

    // R6: square 0x2103 rotates each block to 3,0,1,2
    x_sq = 16'h2103; sel_mask = 0; x_ofs = '0;
    for (int k = 0; k < 8; k++) begin
      exp[64*k +: 16] = 16'd3; exp[64*k+16 +: 16] = 16'd0;
      exp[64*k+32 +: 16] = 16'd1; exp[64*k+48 +: 16] = 16'd2;
    end
    in_valid = 1; @(negedge clk); in_valid = 0;
    chk("R6 square rotate", out_data, exp);

    // R3: wrap, start 30 with all offsets 5 selects word 3 everywhere
    x_buf = fill(3); mode16 = 0; x_start = 30; x_ofs = {16{4'h5}};
    for (int i = 0; i < 16; i++) exp[32*i +: 32] = x_buf[32*3 +: 32];
    in_valid = 1; @(negedge clk); in_valid = 0;
    chk("R3 wrap", out_data, exp);

    // R4: upper mask bits have no effect in 32-bit mode
    y_buf = fill(4); sel_mask = 32'hFFFF_0000;
    in_valid = 1; @(negedge clk); in_valid = 0;
    chk("R4 upper mask ignored", out_data, exp);

    // R2: idle cycles with changing inputs keep the output
    held = out_data;
    for (int c = 0; c < 4; c++) begin
      nxt(v); x_ofs = v; sel_mask = v[31:0]; x_buf = fill(int'(v[7:0]));
      @(negedge clk);
    end
    chk("R2 hold", out_data, held);
    chk("R2 valid low", {511'd0, out_valid}, '0);

    // R7: half lanes in both modes
    for (int m = 0; m < 2; m++) begin
      mode16 = m[0]; half_lanes = 1;
      nxt(v); sel_mask = v[31:0]; nxt(v); x_ofs = v; nxt(v); y_ofs = v;
      fire("R7 half lanes");
      chk("R7 upper zero", {256'd0, out_data[511:256]}, '0);
    end
    half_lanes = 0;

    // R3 R4 R5 R6 sweep over every start value, both modes
    for (int m = 0; m < 2; m++) begin
      for (int st = 0; st < 64; st++) begin
        for (int p = 0; p < 2; p++) begin
          mode16 = m[0];
          x_buf = fill(st * 3 + p); y_buf = fill(st * 5 + p + 1000);
          x_start = 6'(st); y_start = 6'(63 - st);
          nxt(v); x_ofs = v; nxt(v); y_ofs = v;
          nxt(v); x_sq = v[15:0]; y_sq = v[31:16]; sel_mask = v[63:32];
          half_lanes = (st % 7 == 0);
          fire(m ? "R5 R6 sweep16" : "R3 R4 sweep32");
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule